// File: doc/BRIEF.md
# Multi-Port GPIO Register Bank on APB

This block is an APB slave that holds the software-visible state of up to four general-purpose I/O ports, each up to 32 lines wide. For every port it keeps an output value register and a drive-enable register, and it offers a read-only view of the input pins. The input view passes through a two-stage synchronizer. The output value and drive-enable registers go straight to the pad ring on `pin_out` and `pin_oe`.

The interrupt registers are not stored here. The bank decodes their addresses and forwards each access to a separate interrupt unit. That access carries a 3-bit register code, the write flag and the write data, and the interrupt unit returns read data on `irq_rdata`. A static strap, `layout_alt`, chooses which of two address layouts applies to the interrupt registers.

Every transfer finishes in its first access phase, so the bus is never stalled. This block has no streaming interface, and the only flow control is APB's own setup/access sequencing.

Top module: `gpio_apb_bank`

## Requirements
- R1: After reset, every output value and drive-enable bit is 0, so `pin_out` and `pin_oe` are all zero, and every port register reads back as 0.
- R2: The output value register of port p (p = 0..3) is at byte offset 0x00 + 0x0C·p. A write updates it at the end of the access phase, it drives `pin_out[32p+31:32p]`, and it reads back the stored value.
- R3: The drive-enable register of port p is at byte offset 0x04 + 0x0C·p. A 1 bit enables the line's driver (`pin_oe` bit = 1) and a 0 bit leaves the line undriven. The register reads back the stored value.
- R4: The pin register of port p is at byte offset 0x50 + 0x04·p and is read-only. It shows `pin_in` after two rising clock edges of synchronization, and writes to it have no effect.
- R5: Each port has a line count set by a parameter (defaults: port 0 has 32 lines, port 1 has 16, port 2 has 8, port 3 has 32). Bits at or above that count read as 0 in all three port registers, cannot be set by writes, and stay 0 on `pin_out` and `pin_oe`.
- R6: With `layout_alt` = 0, the interrupt offsets decode to these codes on `irq_code`: 0x30 gives 0 (enable), 0x34 gives 1 (mask), 0x38 gives 2 (type), 0x3C gives 3 (polarity), 0x40 gives 4 (status), 0x48 gives 5 (debounce) and 0x4C gives 6 (end-of-interrupt).
- R7: With `layout_alt` = 1, the decode is 0x30 to 0 (enable), 0x34 to 2 (type), 0x38 to 3 (polarity), 0x3C to 4 (status), 0x40 to 6 (end-of-interrupt), 0x44 to 1 (mask) and 0x48 to 5 (debounce).
- R8: Unmapped offsets read as 0, and writes to them change no register. The unmapped offsets are 0x08, 0x14, 0x20, 0x2C, 0x44 in the default layout, 0x4C in the alternate layout, 0x60 and above, and the registers of ports beyond the port count.
- R9: `pready` is always 1 and `pslverr` is always 0.
- R10: `irq_sel` is 1 only during an access phase whose offset decodes to an interrupt register. It then carries `irq_wr` = `pwrite` and `irq_wdata` = `pwdata`, and a read returns `irq_rdata` on `prdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 8 | Byte address; bits 1:0 ignored |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| layout_alt | input | 1 | Interrupt address layout strap |
| pin_in | input | 32·NUM_PORTS | Raw input pin values, port p at bits 32p+31:32p |
| pin_out | output | 32·NUM_PORTS | Output value per line |
| pin_oe | output | 32·NUM_PORTS | Driver enable per line |
| irq_sel | output | 1 | Interrupt register access strobe |
| irq_wr | output | 1 | Forwarded write flag |
| irq_code | output | 3 | Forwarded interrupt register code |
| irq_wdata | output | 32 | Forwarded write data |
| irq_rdata | input | 32 | Read data from the interrupt unit |

## Verification
Most internal faults in this bank appear at the port boundary within one or two cycles. A wrong decode table appears in the same access phase, either as the wrong register reading back or as a wrong `irq_code`. A stored value in the wrong register or at the wrong width appears on `pin_out` or `pin_oe` on the clock after the write. A synchronizer with the wrong depth appears as pin readback one edge too early or too late, so the bench reads in the access phase that follows a single edge and again after two edges. Upper-bit leakage is the fault most likely to go unseen, so ports with narrow line counts are written with all ones and then checked both on the bus and on the pads.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [2:0] {
    IRQ_EN   = 3'd0,
    IRQ_MASK = 3'd1,
    IRQ_TYPE = 3'd2,
    IRQ_POL  = 3'd3,
    IRQ_STAT = 3'd4,
    IRQ_DEB  = 3'd5,
    IRQ_EOI  = 3'd6
  } irq_reg_e;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_DATA = 3'd1,
    SEL_DIR  = 3'd2,
    SEL_EXT  = 3'd3,
    SEL_IRQ  = 3'd4
  } sel_kind_e;

  typedef struct packed {
    sel_kind_e kind;
    logic [1:0] port;
    irq_reg_e  irq;
  } dec_t;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4
) (
  input  logic [7:0] addr,
  input  logic       layout_alt,
  output dec_t       dec
);
  localparam int unsigned DR_STRIDE_W  = 3;   // 0x0C bytes
  localparam int unsigned EXT_BASE_W   = 20;  // 0x50 bytes
  localparam int unsigned INT_BASE_W   = 12;  // 0x30 bytes

  logic [5:0] w;
  logic       unused_lo;
  logic       irq_hit;
  irq_reg_e   irq_code;

  assign w         = addr[7:2];
  assign unused_lo = ^addr[1:0];

  always_comb begin
    irq_hit  = 1'b1;
    irq_code = IRQ_EN;
    if (!layout_alt) begin
      case (w)
        6'(INT_BASE_W + 0): irq_code = IRQ_EN;
        6'(INT_BASE_W + 1): irq_code = IRQ_MASK;
        6'(INT_BASE_W + 2): irq_code = IRQ_TYPE;
        6'(INT_BASE_W + 3): irq_code = IRQ_POL;
        6'(INT_BASE_W + 4): irq_code = IRQ_STAT;
        6'(INT_BASE_W + 6): irq_code = IRQ_DEB;
        6'(INT_BASE_W + 7): irq_code = IRQ_EOI;
        default:            irq_hit  = 1'b0;
      endcase
    end else begin
      case (w)
        6'(INT_BASE_W + 0): irq_code = IRQ_EN;
        6'(INT_BASE_W + 1): irq_code = IRQ_TYPE;
        6'(INT_BASE_W + 2): irq_code = IRQ_POL;
        6'(INT_BASE_W + 3): irq_code = IRQ_STAT;
        6'(INT_BASE_W + 4): irq_code = IRQ_EOI;
        6'(INT_BASE_W + 5): irq_code = IRQ_MASK;
        6'(INT_BASE_W + 6): irq_code = IRQ_DEB;
        default:            irq_hit  = 1'b0;
      endcase
    end
  end

  always_comb begin
    dec.kind = SEL_NONE;
    dec.port = '0;
    dec.irq  = irq_code;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (w == 6'(DR_STRIDE_W * p)) begin
        dec.kind = SEL_DATA;
        dec.port = 2'(p);
      end
      if (w == 6'(DR_STRIDE_W * p + 1)) begin
        dec.kind = SEL_DIR;
        dec.port = 2'(p);
      end
      if (w == 6'(EXT_BASE_W + p)) begin
        dec.kind = SEL_EXT;
        dec.port = 2'(p);
      end
    end
    if (irq_hit) dec.kind = SEL_IRQ;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int unsigned LINES = 32,
  parameter int unsigned W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] ext_q
);
  localparam logic [W-1:0] MASK =
    (LINES >= W) ? {W{1'b1}} : W'((64'd1 << LINES) - 64'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_data) data_q <= wdata & MASK;
      if (wr_dir)  dir_q  <= wdata & MASK;
    end
  end

  gpio_in_sync #(.W(W), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_in & MASK),
    .q    (ext_q)
  );

  // R5
  hi_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_q | dir_q | ext_q) & ~MASK) == '0);

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data |=> $stable(data_q));

  // R3
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(dir_q));
endmodule

// File: rtl/gpio_apb_bank.sv
module gpio_apb_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PORTS  = 4,
  parameter int unsigned DATA_W     = 32,
  parameter logic [NUM_PORTS*6-1:0] PORT_LINES = {6'd32, 6'd8, 6'd16, 6'd32}
) (
  input  logic                        pclk,
  input  logic                        presetn,
  input  logic                        psel,
  input  logic                        penable,
  input  logic                        pwrite,
  input  logic [7:0]                  paddr,
  input  logic [DATA_W-1:0]           pwdata,
  output logic [DATA_W-1:0]           prdata,
  output logic                        pready,
  output logic                        pslverr,
  input  logic                        layout_alt,
  input  logic [NUM_PORTS*DATA_W-1:0] pin_in,
  output logic [NUM_PORTS*DATA_W-1:0] pin_out,
  output logic [NUM_PORTS*DATA_W-1:0] pin_oe,
  output logic                        irq_sel,
  output logic                        irq_wr,
  output logic [2:0]                  irq_code,
  output logic [DATA_W-1:0]           irq_wdata,
  input  logic [DATA_W-1:0]           irq_rdata
);
  dec_t dec;
  logic access;
  logic wr_en;
  logic [DATA_W-1:0] data_a [NUM_PORTS];
  logic [DATA_W-1:0] dir_a  [NUM_PORTS];
  logic [DATA_W-1:0] ext_a  [NUM_PORTS];

  assign access  = psel & penable;
  assign wr_en   = access & pwrite;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  gpio_addr_dec #(.NUM_PORTS(NUM_PORTS)) u_dec (
    .addr      (paddr),
    .layout_alt(layout_alt),
    .dec       (dec)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    assign hit = wr_en && (dec.port == 2'(p));

    gpio_port_regs #(
      .LINES(int'(PORT_LINES[p*6 +: 6])),
      .W    (DATA_W)
    ) u_regs (
      .clk    (pclk),
      .rst_n  (presetn),
      .wr_data(hit && dec.kind == SEL_DATA),
      .wr_dir (hit && dec.kind == SEL_DIR),
      .wdata  (pwdata),
      .pin_in (pin_in[p*DATA_W +: DATA_W]),
      .data_q (data_a[p]),
      .dir_q  (dir_a[p]),
      .ext_q  (ext_a[p])
    );

    assign pin_out[p*DATA_W +: DATA_W] = data_a[p];
    assign pin_oe[p*DATA_W +: DATA_W]  = dir_a[p];
  end

  assign irq_sel   = access && dec.kind == SEL_IRQ;
  assign irq_wr    = pwrite;
  assign irq_code  = dec.irq;
  assign irq_wdata = pwdata;

  always_comb begin
    prdata = '0;
    if (access && !pwrite) begin
      if (dec.kind == SEL_IRQ) prdata = irq_rdata;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (dec.port == 2'(p)) begin
          case (dec.kind)
            SEL_DATA: prdata = data_a[p];
            SEL_DIR:  prdata = dir_a[p];
            SEL_EXT:  prdata = ext_a[p];
            default:  ;
          endcase
        end
      end
    end
  end

  // R8
  unmapped_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && !pwrite && dec.kind == SEL_NONE) |-> prdata == '0);

  // R10
  irq_window_chk: assert property (@(posedge pclk) disable iff (!presetn)
    irq_sel |-> (psel && penable && paddr >= 8'h30 && paddr < 8'h50));

  // R4
  ext_readonly_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (wr_en && dec.kind == SEL_EXT) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

// File: tb/tb_gpio_apb_bank.sv
module tb_gpio_apb_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic pclk = 1'b0;
  logic presetn = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr;
  logic layout_alt = 1'b0;
  logic [NP*32-1:0] pin_in = '0;
  logic [NP*32-1:0] pin_out, pin_oe;
  logic irq_sel, irq_wr;
  logic [2:0] irq_code;
  logic [31:0] irq_wdata;
  logic [31:0] irq_rdata = 32'hC0DE_7A11;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) pclk = ~pclk;

  gpio_apb_bank dut (
    .pclk, .presetn, .psel, .penable, .pwrite, .paddr, .pwdata,
    .prdata, .pready, .pslverr, .layout_alt, .pin_in, .pin_out, .pin_oe,
    .irq_sel, .irq_wr, .irq_code, .irq_wdata, .irq_rdata
  );

  function automatic logic [31:0] lmask(int p);
    case (p)
      1: return 32'h0000_FFFF;
      2: return 32'h0000_00FF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one APB transfer; samples bus outputs inside the access phase
  task automatic apb(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                     output logic [31:0] rd, output logic sel, output logic [2:0] code);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = wd;
    @(negedge pclk);
    penable = 1'b1;
    #1;
    rd = prdata; sel = irq_sel; code = irq_code;
    chk("R9 pready", {31'd0, pready}, 32'd1);
    chk("R9 pslverr", {31'd0, pslverr}, 32'd0);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr32(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] r; logic s; logic [2:0] c;
    apb(1'b1, a, d, r, s, c);
  endtask

  task automatic rd32(input logic [7:0] a, output logic [31:0] d);
    logic s; logic [2:0] c;
    apb(1'b0, a, 32'd0, d, s, c);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    chk("R1 pin_out low", pin_out[31:0] | pin_out[127:96], 32'd0);
    chk("R1 pin_oe low", pin_oe[31:0] | pin_oe[63:32], 32'd0);
    rd32(8'h00, r); chk("R1 data0 reset", r, 32'd0);
    rd32(8'h28, r); chk("R1 dir3 reset", r, 32'd0);
    rd32(8'h54, r); chk("R1 pins1 reset", r, 32'd0);
  endtask

  task automatic t_data_dir();
    logic [31:0] r;
    for (int p = 0; p < NP; p++) begin
      logic [31:0] dv;
      dv = 32'h9C3A_E561 + 32'h0101_0101 * p;
      wr32(8'(12 * p), dv);
      wr32(8'(12 * p + 4), ~dv);
    end
    for (int p = 0; p < NP; p++) begin
      logic [31:0] dv;
      dv = 32'h9C3A_E561 + 32'h0101_0101 * p;
      rd32(8'(12 * p), r);     chk("R2 data readback", r, dv & lmask(p));
      rd32(8'(12 * p + 4), r); chk("R3 dir readback", r, ~dv & lmask(p));
      chk("R2 pin_out", pin_out[p*32 +: 32], dv & lmask(p));
      chk("R3 pin_oe", pin_oe[p*32 +: 32], ~dv & lmask(p));
    end
  endtask

  task automatic t_ext();
    logic [31:0] r;
    @(negedge pclk);
    pin_in[31:0] = 32'h1234_5678;
    psel = 1'b1; pwrite = 1'b0; paddr = 8'h50; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    #1;
    chk("R4 pins after one edge", prdata, 32'd0);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
    rd32(8'h50, r); chk("R4 pins after two edges", r, 32'h1234_5678);
    pin_in[127:96] = 32'hFACE_0FF0;
    repeat (3) @(negedge pclk);
    rd32(8'h5C, r); chk("R4 pins port3", r, 32'hFACE_0FF0);
    wr32(8'h50, 32'hFFFF_FFFF);
    rd32(8'h50, r); chk("R4 write to pins ignored", r, 32'h1234_5678);
    rd32(8'h00, r); chk("R4 write to pins leaves data", r, 32'h9C3A_E561);
  endtask

  task automatic t_width();
    logic [31:0] r;
    wr32(8'h18, 32'hFFFF_FFFF);
    rd32(8'h18, r); chk("R5 port2 data width", r, 32'h0000_00FF);
    chk("R5 port2 pin_out width", pin_out[95:64], 32'h0000_00FF);
    wr32(8'h10, 32'hFFFF_FFFF);
    chk("R5 port1 pin_oe width", pin_oe[63:32], 32'h0000_FFFF);
    pin_in[63:32] = 32'hFFFF_FFFF;
    repeat (3) @(negedge pclk);
    rd32(8'h54, r); chk("R5 port1 pins width", r, 32'h0000_FFFF);
  endtask

  task automatic t_irq(input logic alt);
    logic [7:0] addrs [7];
    logic [2:0] codes [7];
    logic [31:0] r; logic s; logic [2:0] c;
    layout_alt = alt;
    addrs = '{8'h30, 8'h34, 8'h38, 8'h3C, 8'h40, 8'h44, 8'h48};
    if (!alt) begin
      addrs[5] = 8'h4C;
      codes = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd6, 3'd5};
    end else begin
      codes = '{3'd0, 3'd2, 3'd3, 3'd4, 3'd6, 3'd1, 3'd5};
    end
    for (int i = 0; i < 7; i++) begin
      apb(1'b0, addrs[i], 32'd0, r, s, c);
      chk(alt ? "R7 sel" : "R6 sel", {31'd0, s}, 32'd1);
      chk(alt ? "R7 code" : "R6 code", {29'd0, c}, {29'd0, codes[i]});
      chk("R10 read data", r, irq_rdata);
    end
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = 8'h30; pwdata = 32'h0BAD_F00D;
    #1;
    chk("R10 no sel in setup", {31'd0, irq_sel}, 32'd0);
    @(negedge pclk);
    penable = 1'b1;
    #1;
    chk("R10 write sel", {31'd0, irq_sel}, 32'd1);
    chk("R10 write flag", {31'd0, irq_wr}, 32'd1);
    chk("R10 write data", irq_wdata, 32'h0BAD_F00D);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic t_unmapped();
    logic [7:0] holes [6];
    logic [31:0] r; logic s; logic [2:0] c;
    holes = '{8'h08, 8'h14, 8'h20, 8'h2C, 8'h60, 8'hFC};
    layout_alt = 1'b0;
    for (int i = 0; i < 6; i++) begin
      apb(1'b0, holes[i], 32'd0, r, s, c);
      chk("R8 hole reads zero", r, 32'd0);
      chk("R8 hole no irq sel", {31'd0, s}, 32'd0);
    end
    apb(1'b0, 8'h44, 32'd0, r, s, c);
    chk("R8 0x44 default unmapped", {31'd0, s}, 32'd0);
    layout_alt = 1'b1;
    apb(1'b0, 8'h4C, 32'd0, r, s, c);
    chk("R8 0x4C alt unmapped", {31'd0, s}, 32'd0);
    chk("R8 0x4C alt reads zero", r, 32'd0);
    layout_alt = 1'b0;
    wr32(8'h08, 32'h5555_5555);
    wr32(8'h2C, 32'h5555_5555);
    rd32(8'h00, r); chk("R8 hole write leaves data0", r, 32'h9C3A_E561);
    rd32(8'h24, r); chk("R8 hole write leaves data3", r, 32'h9F3D_E864);
    chk("R8 hole write leaves pin_oe3", pin_oe[127:96], ~32'h9F3D_E864);
  endtask

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    t_reset();
    t_data_dir();
    t_ext();
    t_width();
    t_irq(1'b0);
    t_irq(1'b1);
    t_unmapped();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule